// File: doc/BRIEF.md
# Symbol Counter with Timestamp Capture and Compare

This block keeps a 32-bit free-running symbol count that advances on a symbol-rate tick. It stores two timestamps. One is taken when a start-of-frame delimiter is detected. The other is taken when a beacon is detected, or on a manual strobe. Three compare units watch the count, and each unit raises a sticky interrupt flag when the count reaches its target.

In absolute mode a unit's target is its own compare register. In relative mode the target is one of the two timestamps plus the compare register, added modulo 2^32. A per-unit select bit picks which timestamp is used. This lets software schedule an event a fixed number of symbols after a received frame or beacon.

Software reaches every setting through a plain write port and a combinational read port. The register offsets are:
- 0: mode control
- 1: auxiliary control
- 2: source select
- 3: flags
- 4: counter
- 5: beacon stamp
- 6: SFD stamp
- 8, 9 and 10: compare registers for units 0, 1 and 2

Top module: `symtime_cmp`

## Requirements
- R1: After reset the counter, both timestamps, all compare registers, all control registers and all flags are zero. The counter advances by one on each clock where symTick is high, wrapping modulo 2^32. A write to offset 4 loads the counter, and the write has priority over the tick.
- R2: When bit k (k = 0..2) of the mode control register (offset 0) is 0, unit k is in absolute mode. Its flag (cmpFlag bit k) sets on the clock edge at which the counter takes the value held in compare register k (offset 8+k). This includes the wrap from all-ones to zero.
- R3: When mode bit k is 1, unit k is in relative mode. It matches when the counter reaches (timestamp + compare register k) mod 2^32. Bit k of the source select register (offset 2) chooses the timestamp: 0 selects the beacon stamp and 1 selects the SFD stamp.
- R4: A match is detected only on an edge where a tick advances the counter. Several things therefore set no flag:
  - holding the counter on a target value;
  - loading the counter to a target value;
  - writing a compare register equal to the current count.
- R5: Flags are sticky. Writing offset 3 clears each flag whose data bit is 1 and leaves the other flags unchanged. If a match and a clear of the same flag fall on the same edge, the match wins.
- R6: Bit 3 of the mode control register enables automatic capture. When it is set, an sfdDet pulse copies the counter into the SFD stamp. When it is clear, sfdDet has no effect.
- R7: A beaconDet pulse copies the counter into the beacon stamp only when bit 3 of the mode control register is 1 and bit 5 of the auxiliary control register (offset 1) is 0. The mask bit does not affect SFD capture.
- R8: A manBeaconCap pulse always copies the counter into the beacon stamp. Neither the enable bit nor the mask bit affects it.
- R9: When a capture and a tick happen in the same clock, the stamp receives the counter value from before the increment.
- R10: In the auxiliary control register, bits 4:2 (the clock-divider field) and bit 5 read back as written. Bits 7:6 are reserved and always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symTick | input | 1 | Symbol-rate advance strobe |
| sfdDet | input | 1 | Frame delimiter detected strobe |
| beaconDet | input | 1 | Beacon detected strobe |
| manBeaconCap | input | 1 | Manual beacon capture strobe |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| cmpFlag | output | 3 | Sticky compare-match flags, one per unit |
| countVal | output | 32 | Current symbol count |
| beaconStamp | output | 32 | Beacon timestamp |
| sfdStamp | output | 32 | SFD timestamp |

## Verification
The bench drives the count across the all-ones to zero boundary. A unit that compared in a narrower width, or that compared the value from before the increment, would flag one symbol late or never.

A relative target is placed so that timestamp plus offset overflows. A design that saturated the sum, or that swapped the beacon and SFD sources, would miss that match.

Captures are tested with each combination of enable and mask, and in the same cycle as a tick. Wrong gating shows up as a moving stamp where it should hold still. A capture taken after the increment shows up as an off-by-one stamp.

A flag clear that coincides with a match, and a counter that is held or loaded onto its target, catch designs that let the clear win or that compare on every cycle.

// File: rtl/symtime_pkg.sv
package symtime_pkg;
  localparam int CW      = 32;
  localparam int NUM_CMP = 3;
  localparam int ADDR_W  = 4;
  localparam int DIV_W   = 3;

  localparam logic [ADDR_W-1:0] A_MODE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_AUX    = 4'd1;
  localparam logic [ADDR_W-1:0] A_SRC    = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_BSTAMP = 4'd5;
  localparam logic [ADDR_W-1:0] A_SSTAMP = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

  localparam int AUTO_EN_BIT = 3;
  localparam int DIV_LSB     = 2;
  localparam int MASK_BIT    = DIV_LSB + DIV_W;

  typedef struct packed {
    logic               countLoad;
    logic               capBeacon;
    logic               capSfd;
    logic [NUM_CMP-1:0] cmpWe;
  } dpStrobes_t;
endpackage

// File: rtl/symtime_dp.sv
module symtime_dp
  import symtime_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         symTick,
  input  dpStrobes_t                   st,
  input  logic [CW-1:0]                wrData,
  input  logic [NUM_CMP-1:0]           relMode,
  input  logic [NUM_CMP-1:0]           srcSel,
  output logic [CW-1:0]                countVal,
  output logic [CW-1:0]                beaconStamp,
  output logic [CW-1:0]                sfdStamp,
  output logic [NUM_CMP-1:0][CW-1:0]   cmpRegs,
  output logic [NUM_CMP-1:0]           matchHit
);
  logic [CW-1:0] countNext;
  logic          advance;

  assign advance   = symTick && !st.countLoad;
  assign countNext = countVal + CW'(1);

  always_ff @(posedge clk) begin
    if (!rstN)              countVal <= '0;
    else if (st.countLoad)  countVal <= wrData;
    else if (symTick)       countVal <= countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beaconStamp <= '0;
      sfdStamp    <= '0;
    end else begin
      if (st.capBeacon) beaconStamp <= countVal;
      if (st.capSfd)    sfdStamp    <= countVal;
    end
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_unit
    logic [CW-1:0] baseStamp;
    logic [CW-1:0] target;

    always_ff @(posedge clk) begin
      if (!rstN)             cmpRegs[k] <= '0;
      else if (st.cmpWe[k])  cmpRegs[k] <= wrData;
    end

    assign baseStamp   = srcSel[k] ? sfdStamp : beaconStamp;
    assign target      = relMode[k] ? (baseStamp + cmpRegs[k]) : cmpRegs[k];
    assign matchHit[k] = advance && (countNext == target);
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (symTick && !st.countLoad) |=> countVal == $past(countVal) + CW'(1));

  // R9
  sfd_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.capSfd |=> sfdStamp == $past(countVal));

  // R4
  hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|matchHit) |=> countVal != $past(countVal));
endmodule

// File: rtl/symtime_ctrl.sv
module symtime_ctrl
  import symtime_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sfdDet,
  input  logic                        beaconDet,
  input  logic                        manBeaconCap,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [CW-1:0]               regWdata,
  input  logic [NUM_CMP-1:0]          matchHit,
  input  logic [CW-1:0]               countVal,
  input  logic [CW-1:0]               beaconStamp,
  input  logic [CW-1:0]               sfdStamp,
  input  logic [NUM_CMP-1:0][CW-1:0]  cmpRegs,
  output dpStrobes_t                  st,
  output logic [NUM_CMP-1:0]          relMode,
  output logic [NUM_CMP-1:0]          srcSel,
  output logic [NUM_CMP-1:0]          cmpFlag,
  output logic [CW-1:0]               regRdata
);
  logic               autoEn;
  logic               bcnMask;
  logic [DIV_W-1:0]   divSel;
  logic [NUM_CMP-1:0] flagClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relMode <= '0;
      autoEn  <= 1'b0;
      bcnMask <= 1'b0;
      divSel  <= '0;
      srcSel  <= '0;
    end else if (regWe) begin
      if (regAddr == A_MODE) begin
        relMode <= regWdata[NUM_CMP-1:0];
        autoEn  <= regWdata[AUTO_EN_BIT];
      end
      if (regAddr == A_AUX) begin
        divSel  <= regWdata[DIV_LSB +: DIV_W];
        bcnMask <= regWdata[MASK_BIT];
      end
      if (regAddr == A_SRC) srcSel <= regWdata[NUM_CMP-1:0];
    end
  end

  assign flagClr = (regWe && regAddr == A_FLAG) ? regWdata[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) cmpFlag <= '0;
    else       cmpFlag <= (cmpFlag & ~flagClr) | matchHit;
  end

  always_comb begin
    st.countLoad = regWe && (regAddr == A_COUNT);
    st.capSfd    = sfdDet && autoEn;
    st.capBeacon = manBeaconCap || (beaconDet && autoEn && !bcnMask);
    for (int k = 0; k < NUM_CMP; k++)
      st.cmpWe[k] = regWe && (regAddr == ADDR_W'(int'(A_CMP0) + k));
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_MODE: begin
        regRdata[NUM_CMP-1:0] = relMode;
        regRdata[AUTO_EN_BIT] = autoEn;
      end
      A_AUX: begin
        regRdata[DIV_LSB +: DIV_W] = divSel;
        regRdata[MASK_BIT]         = bcnMask;
      end
      A_SRC:    regRdata[NUM_CMP-1:0] = srcSel;
      A_FLAG:   regRdata[NUM_CMP-1:0] = cmpFlag;
      A_COUNT:  regRdata = countVal;
      A_BSTAMP: regRdata = beaconStamp;
      A_SSTAMP: regRdata = sfdStamp;
      default: begin
        for (int k = 0; k < NUM_CMP; k++)
          if (regAddr == ADDR_W'(int'(A_CMP0) + k)) regRdata = cmpRegs[k];
      end
    endcase
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|matchHit) |=> (cmpFlag & $past(matchHit)) == $past(matchHit));

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cmpFlag & ~$past(cmpFlag)) & ~$past(matchHit)) == '0);

  // R6
  sfd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfdDet && !autoEn) |=> $stable(sfdStamp));

  // R7
  bcn_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beaconDet && !manBeaconCap && (bcnMask || !autoEn)) |=> $stable(beaconStamp));

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_AUX) |-> regRdata[7:6] == 2'b00);
endmodule

// File: rtl/symtime_cmp.sv
module symtime_cmp
  import symtime_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              symTick,
  input  logic              sfdDet,
  input  logic              beaconDet,
  input  logic              manBeaconCap,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CW-1:0]     regWdata,
  output logic [CW-1:0]     regRdata,
  output logic [NUM_CMP-1:0] cmpFlag,
  output logic [CW-1:0]     countVal,
  output logic [CW-1:0]     beaconStamp,
  output logic [CW-1:0]     sfdStamp
);
  dpStrobes_t                 st;
  logic [NUM_CMP-1:0]         relMode;
  logic [NUM_CMP-1:0]         srcSel;
  logic [NUM_CMP-1:0]         matchHit;
  logic [NUM_CMP-1:0][CW-1:0] cmpRegs;

  symtime_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sfdDet(sfdDet), .beaconDet(beaconDet),
    .manBeaconCap(manBeaconCap), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .matchHit(matchHit), .countVal(countVal),
    .beaconStamp(beaconStamp), .sfdStamp(sfdStamp), .cmpRegs(cmpRegs),
    .st(st), .relMode(relMode), .srcSel(srcSel), .cmpFlag(cmpFlag),
    .regRdata(regRdata)
  );

  symtime_dp u_dp (
    .clk(clk), .rstN(rstN), .symTick(symTick), .st(st), .wrData(regWdata),
    .relMode(relMode), .srcSel(srcSel), .countVal(countVal),
    .beaconStamp(beaconStamp), .sfdStamp(sfdStamp), .cmpRegs(cmpRegs),
    .matchHit(matchHit)
  );
endmodule

// File: tb/symtime_cmp_tb.sv
module symtime_cmp_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        symTick = 1'b0, sfdDet = 1'b0, beaconDet = 1'b0, manBeaconCap = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, countVal, beaconStamp, sfdStamp;
  logic [2:0]  cmpFlag;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  symtime_cmp u_dut (
    .clk(clk), .rstN(rstN), .symTick(symTick), .sfdDet(sfdDet),
    .beaconDet(beaconDet), .manBeaconCap(manBeaconCap), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmpFlag(cmpFlag), .countVal(countVal), .beaconStamp(beaconStamp),
    .sfdStamp(sfdStamp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); symTick = 1;
      @(negedge clk); symTick = 0;
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sfdDet = 1; 1: beaconDet = 1; default: manBeaconCap = 1;
    endcase
    @(negedge clk); sfdDet = 0; beaconDet = 0; manBeaconCap = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 reset count", countVal, 0);
    chk("R1 reset flags", {29'd0, cmpFlag}, 0);
    chk("R1 reset stamps", beaconStamp | sfdStamp, 0);
    rd(4'd0, d); chk("R1 reset mode", d, 0);
    rd(4'd9, d); chk("R1 reset cmp", d, 0);
  endtask

  task automatic t_count;
    ticks(5); chk("R1 count 5", countVal, 5);
    wr(4'd4, 32'd100); chk("R1 load", countVal, 100);
    @(negedge clk); regWe = 1; regAddr = 4'd4; regWdata = 0; symTick = 1;
    @(negedge clk); regWe = 0; symTick = 0;
    chk("R1 load beats tick", countVal, 0);
  endtask

  task automatic t_abs;
    wr(4'd8, 32'd10); wr(4'd0, 0);
    ticks(9); chk("R2 before", {29'd0, cmpFlag}, 0);
    ticks(1); chk("R2 abs hit", {29'd0, cmpFlag}, 1);
    chk("R2 abs count", countVal, 10);
    wr(4'd3, 7); wr(4'd10, 32'h1234);
    wr(4'd4, 32'hFFFF_FFFE);
    ticks(1); chk("R2 pre-wrap", {29'd0, cmpFlag}, 0);
    ticks(1); chk("R2 wrap hit", {29'd0, cmpFlag}, 3'b010);
    wr(4'd3, 7);
  endtask

  task automatic t_hold;
    wr(4'd9, 32'd0);
    repeat (5) @(negedge clk);
    chk("R4 hold", {29'd0, cmpFlag}, 0);
    wr(4'd4, 32'd10);
    repeat (3) @(negedge clk);
    chk("R4 load onto target", {29'd0, cmpFlag}, 0);
  endtask

  task automatic t_w1c;
    wr(4'd8, 32'd11); ticks(1);
    chk("R5 set", {29'd0, cmpFlag}, 1);
    wr(4'd3, 0); chk("R5 zero write", {29'd0, cmpFlag}, 1);
    wr(4'd3, 2); chk("R5 other bit", {29'd0, cmpFlag}, 1);
    wr(4'd3, 1); chk("R5 clear", {29'd0, cmpFlag}, 0);
    wr(4'd8, 32'd12);
    @(negedge clk); regWe = 1; regAddr = 4'd3; regWdata = 1; symTick = 1;
    @(negedge clk); regWe = 0; symTick = 0;
    chk("R5 set wins", {29'd0, cmpFlag}, 1);
    wr(4'd3, 7);
  endtask

  task automatic t_capture;
    wr(4'd0, 0);
    pulse(0); chk("R6 sfd disabled", sfdStamp, 0);
    pulse(1); chk("R7 beacon disabled", beaconStamp, 0);
    pulse(2); chk("R8 manual disabled", beaconStamp, 12);
    ticks(1); wr(4'd0, 8);
    pulse(0); chk("R6 sfd enabled", sfdStamp, 13);
    pulse(1); chk("R7 beacon enabled", beaconStamp, 13);
    ticks(1); wr(4'd1, 32'h20);
    pulse(1); chk("R7 beacon masked", beaconStamp, 13);
    pulse(0); chk("R7 sfd unmasked", sfdStamp, 14);
    pulse(2); chk("R8 manual masked", beaconStamp, 14);
    wr(4'd1, 0); ticks(1);
    pulse(1); chk("R7 beacon unmasked", beaconStamp, 15);
  endtask

  task automatic t_same;
    @(negedge clk); sfdDet = 1; manBeaconCap = 1; symTick = 1;
    @(negedge clk); sfdDet = 0; manBeaconCap = 0; symTick = 0;
    chk("R9 sfd pre", sfdStamp, 15);
    chk("R9 beacon pre", beaconStamp, 15);
    chk("R9 count", countVal, 16);
  endtask

  task automatic t_rel;
    wr(4'd4, 32'hFFFF_FFF0); wr(4'd0, 8);
    pulse(0); chk("R3 stamp", sfdStamp, 32'hFFFF_FFF0);
    wr(4'd10, 32'h20); wr(4'd2, 3'b100); wr(4'd0, 8 | 4);
    wr(4'd3, 7); wr(4'd4, 32'h0F);
    ticks(1); chk("R3 sfd rel wrap", {29'd0, cmpFlag}, 3'b100);
    pulse(2); wr(4'd8, 3); wr(4'd0, 8 | 4 | 1); wr(4'd3, 7);
    ticks(2); chk("R3 before beacon rel", {29'd0, cmpFlag}, 0);
    ticks(1); chk("R3 beacon rel", {29'd0, cmpFlag}, 1);
    chk("R3 count", countVal, 32'h13);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'd1, 32'hFF); rd(4'd1, d);
    chk("R10 aux readback", d, 32'h3C);
    rd(4'd2, d); chk("R3 src readback", d, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset; t_count; t_abs; t_hold; t_w1c; t_capture; t_same; t_rel; t_regs;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule